// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block produces a divided clock from its input clock. The ratio comes from two small count fields held in one 32-bit configuration word. The output stays high for one more input cycle than the high-phase count says and low for one more cycle than the low-phase count says, so a full output period lasts high count + low count + 2 input cycles. A bypass control lets the input clock pass straight to the output instead.

Software does not change the running divider directly. It writes the new counts, the bypass choice and an apply-request bit in a single word. The request bit stays set until the divider reaches the end of a whole output period. At that point the divider loads the new settings and clears the request bit in the same cycle, so software polls the word until the bit reads 0. While a request is pending, further writes are dropped, so the period in progress is never cut short. A parameter narrows the count fields to 3 bits for a domain that needs less range. A ratio R is split into a high count of floor(R/2) - 1 and a low count of R minus that minus 2. This gives a duty cycle close to one half.

Top module: `wh_clk_divider`

## Requirements
- R1: Field layout of the configuration word. Bits [19:16] hold the high-phase count, bits [23:20] hold the low-phase count, bit 24 selects bypass (1 = bypass) and bit 25 is the apply request (1 = pending). A read returns these bits as last accepted, and every other bit reads 0.
- R2: When not bypassed, the output is high for high count + 1 input cycles and low for low count + 1 input cycles, giving a period of high count + low count + 2.
- R3: A write that has bit 25 set makes bit 25 read 1 at once. The new fields show on readback immediately but take effect only at the next end of a complete output period. Bit 25 reads 0 from that cycle on. A write with bit 25 clear changes the readback only and leaves the running period unchanged.
- R4: While bit 25 reads 1, writes are ignored: the readback and the settings that are applied next stay as they were.
- R5: With bypass applied, the output equals the input clock. Bypass is entered or left only at the end of a period, in a cycle where the divided output is low.
- R6: With CNT_W = 3, the top bit of each count field (bits 19 and 23) is ignored on write and reads 0. The counts then range from 0 to 7.
- R7: After a synchronous reset, both counts are 0, bypass is 0 and bit 25 is 0. The readback is 0 and the output divides by 2.
- R8: For a ratio R, a high count of floor(R/2) - 1 and a low count of R - floor(R/2) - 1 give a period of exactly R cycles with floor(R/2) of them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration readback word |
| div_clk | output | 1 | Divided or bypassed output clock |

## Verification
A wrong count register shows at the ports within one output period, as a high or low run of the wrong length. A request flag stuck at 1 shows as a poll that never completes. A flag cleared too early shows as a new period that starts before the old one is complete. A held write that leaks into the shadow settings shows on the very next readback, before the request completes. A bypass or field-mask error shows within one cycle after the request clears.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int REG_W      = 32;
    localparam int FIELD_SLOT = 4;
    localparam int HI_LSB     = 16;
    localparam int LO_LSB     = 20;
    localparam int BYP_BIT    = 24;
    localparam int REQ_BIT    = 25;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    typedef struct packed {
        logic                  byp;
        logic [FIELD_SLOT-1:0] lo_cnt;
        logic [FIELD_SLOT-1:0] hi_cnt;
    } div_cfg_t;

    function automatic logic [FIELD_SLOT-1:0] field_mask(input int unsigned width);
        logic [FIELD_SLOT-1:0] m;
        for (int i = 0; i < FIELD_SLOT; i++) begin
            m[i] = (i < int'(width));
        end
        return m;
    endfunction

    function automatic div_cfg_t unpack_cfg(input logic [REG_W-1:0] w,
                                            input int unsigned width);
        div_cfg_t c;
        c.hi_cnt = w[HI_LSB +: FIELD_SLOT] & field_mask(width);
        c.lo_cnt = w[LO_LSB +: FIELD_SLOT] & field_mask(width);
        c.byp    = w[BYP_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input div_cfg_t c, input logic pend);
        logic [REG_W-1:0] w;
        w = '0;
        w[HI_LSB +: FIELD_SLOT] = c.hi_cnt;
        w[LO_LSB +: FIELD_SLOT] = c.lo_cnt;
        w[BYP_BIT]              = c.byp;
        w[REQ_BIT]              = pend;
        return w;
    endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             boundary,
    output div_cfg_t         shadow_o,
    output logic             pend_o,
    output logic [REG_W-1:0] rdata_o
);

    div_cfg_t shadow_q;
    logic     pend_q;
    logic     unused_wbits;

    assign unused_wbits = ^{wdata[REG_W-1:REQ_BIT+1], wdata[HI_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (we && !pend_q) begin
            shadow_q <= unpack_cfg(wdata, CNT_W);
            pend_q   <= wdata[REQ_BIT];
        end else if (pend_q && boundary) begin
            pend_q   <= 1'b0;
        end
    end

    assign shadow_o = shadow_q;
    assign pend_o   = pend_q;
    assign rdata_o  = pack_cfg(shadow_q, pend_q);

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t shadow,
    input  logic     pend,
    output logic     boundary_o,
    output logic     q_o,
    output logic     byp_o
);

    div_cfg_t           act_q;
    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FIELD_SLOT-1:0] cnt_ext;
    logic               hi_last;
    logic               lo_last;

    assign cnt_ext    = FIELD_SLOT'(cnt_q);
    assign hi_last    = (phase_q == PH_HIGH) && (cnt_ext == act_q.hi_cnt);
    assign lo_last    = (phase_q == PH_LOW)  && (cnt_ext == act_q.lo_cnt);
    assign boundary_o = lo_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else begin
            if (hi_last) begin
                phase_q <= PH_LOW;
                cnt_q   <= '0;
            end else if (lo_last) begin
                phase_q <= PH_HIGH;
                cnt_q   <= '0;
                if (pend) begin
                    act_q <= shadow;
                end
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign q_o   = (phase_q == PH_HIGH);
    assign byp_o = act_q.byp;

endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel (
    input  logic clk_in,
    input  logic byp,
    input  logic q,
    output logic clk_out
);

    always_comb begin
        if (byp) begin
            clk_out = clk_in;
        end else begin
            clk_out = q;
        end
    end

endmodule

// File: rtl/wh_clk_divider.sv
module wh_clk_divider
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        div_clk
);

    div_cfg_t shadow;
    logic     pend;
    logic     boundary;
    logic     div_q;
    logic     act_byp;

    generate
        if (CNT_W < 1 || CNT_W > FIELD_SLOT) begin : g_bad_width
            initial $error("CNT_W must lie between 1 and 4");
        end
    endgenerate

    clkdiv_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .boundary (boundary),
        .shadow_o (shadow),
        .pend_o   (pend),
        .rdata_o  (cfg_rdata)
    );

    clkdiv_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .shadow     (shadow),
        .pend       (pend),
        .boundary_o (boundary),
        .q_o        (div_q),
        .byp_o      (act_byp)
    );

    clkdiv_outsel u_out (
        .clk_in  (clk),
        .byp     (act_byp),
        .q       (div_q),
        .clk_out (div_clk)
    );

endmodule

// File: rtl/wh_clk_divider_chk.sv
module wh_clk_divider_chk #(
    parameter int CNT_W = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        pend,
    input logic        div_q,
    input logic        act_byp,
    input logic [31:0] cfg_rdata
);

    localparam int RUN_W   = CNT_W + 2;
    localparam int RUN_MAX = 1 << CNT_W;

    logic [RUN_W-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else if (div_q) begin
            if (hi_run != {RUN_W{1'b1}}) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (cfg_rdata == 32'h0 && !div_q && !act_byp)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        hi_run <= RUN_W'(RUN_MAX)); // R2

    AST_REQ_DROP_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> (!$past(div_q) && div_q)); // R3

    AST_HELD_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(pend) |-> $stable(cfg_rdata[24:16])); // R4

    AST_BYPASS_AT_LOW: assert property (@(posedge clk) disable iff (rst)
        $changed(act_byp) |-> !$past(div_q)); // R5

endmodule

bind wh_clk_divider wh_clk_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .div_q     (div_q),
    .act_byp   (act_byp),
    .cfg_rdata (cfg_rdata)
);

// File: tb/tb_wh_clk_divider.sv
`timescale 1ns/1ps
module tb_wh_clk_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [31:0] wd_a = '0, wd_b = '0;
    logic [31:0] rd_a, rd_b;
    logic        out_a, out_b;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wh_clk_divider dut (
        .clk(clk), .rst(rst), .cfg_we(we_a), .cfg_wdata(wd_a),
        .cfg_rdata(rd_a), .div_clk(out_a)
    );

    wh_clk_divider #(.CNT_W(3)) dut_n (
        .clk(clk), .rst(rst), .cfg_we(we_b), .cfg_wdata(wd_b),
        .cfg_rdata(rd_b), .div_clk(out_b)
    );

    // ratio, expected high cycles, expected low cycles
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{2, 1, 1}, '{3, 1, 2}, '{4, 2, 2}, '{5, 2, 3},
        '{7, 3, 4}, '{10, 5, 5}, '{17, 8, 9}, '{32, 16, 16}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int hi, input int lo,
                                         input bit byp, input bit req);
        return (32'(lo) << 20) | (32'(hi) << 16) | (32'(byp) << 24) | (32'(req) << 25);
    endfunction

    task automatic wr(input bit nar, input logic [31:0] d);
        @(negedge clk);
        if (nar) begin we_b = 1'b1; wd_b = d; end
        else     begin we_a = 1'b1; wd_a = d; end
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic wait_done(input bit nar, input string tag);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!(nar ? rd_b[25] : rd_a[25])) return;
        end
        chk(1'b0, tag, 1, 0);
    endtask

    task automatic measure(input bit nar, output int hi, output int lo);
        logic prev, cur;
        hi = 0;
        lo = 0;
        @(negedge clk);
        prev = nar ? out_b : out_a;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            cur = nar ? out_b : out_a;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!(nar ? out_b : out_a)) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (nar ? out_b : out_a) break;
            lo++;
        end
    endtask

    initial begin
        #(20.0 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int hi, lo, w, h;
        logic [31:0] d;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_a == 32'h0, "R7 readback after reset", rd_a, 0);
        chk(rd_b == 32'h0, "R7 narrow readback after reset", rd_b, 0);
        measure(1'b0, hi, lo);
        chk(hi == 1 && lo == 1, "R7 divide by two after reset", hi * 16 + lo, 17);

        // table walk: ratio recipe and run lengths
        for (int v = 0; v < NV; v++) begin
            w = VEC[v][0] / 2 - 1;
            h = VEC[v][0] - w - 2;
            d = word(w, h, 1'b0, 1'b1);
            wr(1'b0, d);
            chk(rd_a == d, "R1 R3 readback while pending", rd_a, d);
            wait_done(1'b0, "R3 request never cleared");
            chk(rd_a == word(w, h, 1'b0, 1'b0), "R3 request cleared", rd_a, word(w, h, 1'b0, 1'b0));
            measure(1'b0, hi, lo);
            chk(hi == VEC[v][1], "R2 R8 high run", hi, VEC[v][1]);
            chk(lo == VEC[v][2], "R2 R8 low run", lo, VEC[v][2]);
        end

        // R4: second write while pending is dropped
        wr(1'b0, word(2, 5, 1'b0, 1'b1));
        wr(1'b0, word(9, 1, 1'b0, 1'b1));
        chk(rd_a == word(2, 5, 1'b0, 1'b1), "R4 held write readback", rd_a, word(2, 5, 1'b0, 1'b1));
        wait_done(1'b0, "R4 request never cleared");
        measure(1'b0, hi, lo);
        chk(hi == 3 && lo == 6, "R4 applied first settings", hi * 16 + lo, 3 * 16 + 6);

        // R3: write without request changes readback only
        wr(1'b0, word(7, 7, 1'b0, 1'b0));
        chk(rd_a == word(7, 7, 1'b0, 1'b0), "R3 plain write readback", rd_a, word(7, 7, 1'b0, 1'b0));
        measure(1'b0, hi, lo);
        chk(hi == 3 && lo == 6, "R3 plain write not applied", hi * 16 + lo, 3 * 16 + 6);
        wr(1'b0, word(7, 7, 1'b0, 1'b1));
        wait_done(1'b0, "R3 request never cleared");
        measure(1'b0, hi, lo);
        chk(hi == 8 && lo == 8, "R3 applied after request", hi * 16 + lo, 8 * 16 + 8);

        // R5: bypass in and out
        wr(1'b0, word(7, 7, 1'b1, 1'b1));
        wait_done(1'b0, "R5 request never cleared");
        for (int i = 0; i < 3; i++) begin
            logic s1, s2;
            @(posedge clk);
            #5 s1 = out_a;
            #10 s2 = out_a;
            chk(s1 == 1'b1 && s2 == 1'b0, "R5 bypass follows input", {s1, s2}, 2);
        end
        wr(1'b0, word(1, 0, 1'b0, 1'b1));
        wait_done(1'b0, "R5 request never cleared");
        measure(1'b0, hi, lo);
        chk(hi == 2 && lo == 1, "R5 leave bypass", hi * 16 + lo, 2 * 16 + 1);

        // R6: narrow variant masks the top field bits
        measure(1'b1, hi, lo);
        chk(hi == 1 && lo == 1, "R6 R7 narrow divide by two", hi * 16 + lo, 17);
        wr(1'b1, word(15, 14, 1'b0, 1'b1));
        wait_done(1'b1, "R6 request never cleared");
        chk(rd_b == word(7, 6, 1'b0, 1'b0), "R6 narrow readback masked", rd_b, word(7, 6, 1'b0, 1'b0));
        measure(1'b1, hi, lo);
        chk(hi == 8 && lo == 7, "R6 narrow run lengths", hi * 16 + lo, 8 * 16 + 7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule